// File: doc/BRIEF.md
# Predicated Vector Gather Load Sequencer

This block carries out one gather load of 64-bit words into a vector. A start strobe hands it an instruction word, a scalar base value from the general register file, the current stack pointer, a vector of per-lane index values and a byte-granular predicate. The block checks that the word belongs to the supported gather-load family and picks how each index is widened and scaled from the word's own bits. It then visits the lanes one at a time. For every lane whose predicate bit is set it issues one 8-byte read at base plus adjusted index.

Reads leave through a request port that has at most one transfer in flight. Each returned word fills its lane of the result vector. Lanes whose predicate bit is clear never touch memory and read back as zero. When every lane has been handled, the block raises `done` for one cycle and the result vector stays valid. An illegal word, a misaligned stack pointer, or an error response ends the operation with a fault flag instead. The fault flags hold until the next accepted start.

Top module: `gather_ld_seq`

## Requirements
- R1: After reset, `busy`, `done`, `req_valid`, `rsp_ready` and all three fault flags are low, and `result` is all zeros.
- R2: A start is accepted only if the word meets all three conditions: instr[31:23] = 9'b110001011, instr[14:13] = 2'b10, and instr[22] = 1 whenever instr[15] = 1. Any other word sets `undef_fault`, issues no request and gives no `done`.
- R3: When instr[15] = 0, only index bits [31:0] of a lane form the offset. They are zero-extended when instr[22] = 0 and sign-extended when instr[22] = 1. When instr[15] = 1, the whole 64-bit lane index is the offset.
- R4: When instr[21] = 1, the offset is shifted left by 3 before it is added. When instr[21] = 0, it is added unshifted.
- R5: The request address is base + offset, modulo 2^64. The base is `sp_base` when instr[9:5] = 31 and `gpr_base` otherwise.
- R6: Lane e is active when `pred[8*e]` is 1, and every other predicate bit is ignored. Active lanes are requested in ascending lane order. An inactive lane issues no request and reads back as zero.
- R7: When instr[9:5] = 31 and `sp_base[3:0]` is not zero, `align_fault` is set and no request is issued.
- R8: Once `req_valid` is high it stays high, with `req_addr` unchanged, until `req_ready` is seen. No new request is raised while a response is awaited (`rsp_ready` high).
- R9: A response with `rsp_err` high sets `mem_fault` and ends the operation at once. No further request and no `done` follow.
- R10: `done` is a one-cycle pulse once every lane is handled without error. `result` then holds each lane's returned word until the next start. Each accepted start clears the fault flags.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begin an operation (taken only while not busy) |
| instr | input | 32 | Instruction word |
| gpr_base | input | 64 | Scalar base from the general register file |
| sp_base | input | 64 | Stack pointer value |
| index_vec | input | LANES*64 | Per-lane index values, lane 0 in the low bits |
| pred | input | LANES*8 | Predicate, one bit per byte |
| req_valid | output | 1 | Read request valid |
| req_addr | output | 64 | Read address |
| req_ready | input | 1 | Memory accepts the request |
| rsp_valid | input | 1 | Read response valid |
| rsp_ready | output | 1 | Block waits for a response |
| rsp_data | input | 64 | Returned word |
| rsp_err | input | 1 | Response carries an error |
| result | output | LANES*64 | Assembled vector |
| done | output | 1 | One-cycle completion pulse |
| busy | output | 1 | Operation in progress |
| undef_fault | output | 1 | Word is not a supported encoding |
| align_fault | output | 1 | Stack pointer misaligned |
| mem_fault | output | 1 | Error response received |

## Verification
The bench uses the default parameters: eight 64-bit lanes, 64-bit addresses and a 4-bit stack-pointer alignment check. With eight lanes it can use predicates that mix active and idle lanes with noise bits between the lane bits, a fully idle predicate, and an error on a middle lane that must cut off the lanes after it. With full 64-bit arithmetic, an index near 2^64 and negative sign-extended offsets can wrap around zero. The memory model changes its response latency between operations, which exercises the single-outstanding handshake under stalls.

// File: rtl/gather_pkg.sv
package gather_pkg;
  typedef enum logic [1:0] {
    ST_IDLE,
    ST_SCAN,
    ST_REQ,
    ST_WAIT
  } seq_state_e;

  typedef struct packed {
    logic legal;
    logic wide;
    logic sext;
    logic scaled;
    logic use_sp;
  } gdec_t;

  localparam logic [8:0] OPC_HI  = 9'b110001011;
  localparam logic [1:0] OPC_MID = 2'b10;
  localparam logic [4:0] SP_REG  = 5'd31;
endpackage

// File: rtl/gather_decode.sv
module gather_decode
  import gather_pkg::*;
(
  input  logic [31:0] instr,
  output gdec_t       dec
);
  // register-number fields are consumed outside this block
  logic unused_fields;
  assign unused_fields = ^{instr[20:16], instr[12:10], instr[4:0]};

  always_comb begin
    dec.wide   = instr[15];
    dec.sext   = !instr[15] && instr[22];
    dec.scaled = instr[21];
    dec.use_sp = (instr[9:5] == SP_REG);
    dec.legal  = (instr[31:23] == OPC_HI) && (instr[14:13] == OPC_MID) &&
                 (!instr[15] || instr[22]);
  end
endmodule

// File: rtl/gather_addr_gen.sv
module gather_addr_gen #(
  parameter int ADDR_W   = 64,
  parameter int NARROW_W = 32,
  parameter int SCALE_SH = 3
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [ADDR_W-1:0] index,
  input  logic              wide,
  input  logic              sext,
  input  logic              scaled,
  output logic [ADDR_W-1:0] addr
);
  localparam int EXT_W = ADDR_W - NARROW_W;

  logic [ADDR_W-1:0] offs;

  always_comb begin
    if (wide)
      offs = index;
    else if (sext)
      offs = {{EXT_W{index[NARROW_W-1]}}, index[NARROW_W-1:0]};
    else
      offs = {{EXT_W{1'b0}}, index[NARROW_W-1:0]};
    addr = base + (scaled ? (offs << SCALE_SH) : offs);
  end
endmodule

// File: rtl/gather_ld_seq.sv
module gather_ld_seq
  import gather_pkg::*;
#(
  parameter int LANES         = 8,
  parameter int DATA_W        = 64,
  parameter int ADDR_W        = 64,
  parameter int SP_ALIGN_BITS = 4
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    start,
  input  logic [31:0]             instr,
  input  logic [ADDR_W-1:0]       gpr_base,
  input  logic [ADDR_W-1:0]       sp_base,
  input  logic [LANES*DATA_W-1:0] index_vec,
  input  logic [LANES*DATA_W/8-1:0] pred,
  output logic                    req_valid,
  output logic [ADDR_W-1:0]       req_addr,
  input  logic                    req_ready,
  input  logic                    rsp_valid,
  output logic                    rsp_ready,
  input  logic [DATA_W-1:0]       rsp_data,
  input  logic                    rsp_err,
  output logic [LANES*DATA_W-1:0] result,
  output logic                    done,
  output logic                    busy,
  output logic                    undef_fault,
  output logic                    align_fault,
  output logic                    mem_fault
);
  localparam int PRED_STRIDE = DATA_W / 8;
  localparam int LANE_W      = (LANES > 1) ? $clog2(LANES) : 1;
  localparam logic [LANE_W-1:0] LAST_LANE = LANE_W'(LANES - 1);

  seq_state_e              state;
  gdec_t                   dec;
  logic [LANE_W-1:0]       lane;
  logic [LANES-1:0]        pred_lane;
  logic [LANES-1:0]        pred_q;
  logic [LANES*DATA_W-1:0] idx_q;
  logic [ADDR_W-1:0]       base_q;
  logic                    wide_q, sext_q, scaled_q;
  logic [ADDR_W-1:0]       lane_addr;
  logic [DATA_W-1:0]       lane_index;
  logic                    sp_misaligned;
  logic                    unused_pred;

  // only the lowest predicate bit of each lane's byte group matters
  assign unused_pred = ^pred;

  for (genvar e = 0; e < LANES; e++) begin : g_pred
    assign pred_lane[e] = pred[e*PRED_STRIDE];
  end

  gather_decode u_dec (
    .instr (instr),
    .dec   (dec)
  );

  assign lane_index    = idx_q[lane*DATA_W +: DATA_W];
  assign sp_misaligned = (sp_base[SP_ALIGN_BITS-1:0] != '0);

  gather_addr_gen #(
    .ADDR_W   (ADDR_W),
    .NARROW_W (32),
    .SCALE_SH (3)
  ) u_agen (
    .base   (base_q),
    .index  (lane_index[ADDR_W-1:0]),
    .wide   (wide_q),
    .sext   (sext_q),
    .scaled (scaled_q),
    .addr   (lane_addr)
  );

  assign busy      = (state != ST_IDLE);
  assign rsp_ready = (state == ST_WAIT);

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= ST_IDLE;
      lane        <= '0;
      pred_q      <= '0;
      idx_q       <= '0;
      base_q      <= '0;
      wide_q      <= 1'b0;
      sext_q      <= 1'b0;
      scaled_q    <= 1'b0;
      req_valid   <= 1'b0;
      req_addr    <= '0;
      result      <= '0;
      done        <= 1'b0;
      undef_fault <= 1'b0;
      align_fault <= 1'b0;
      mem_fault   <= 1'b0;
    end else begin
      done <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            undef_fault <= 1'b0;
            align_fault <= 1'b0;
            mem_fault   <= 1'b0;
            if (!dec.legal) begin
              undef_fault <= 1'b1;
            end else if (dec.use_sp && sp_misaligned) begin
              align_fault <= 1'b1;
            end else begin
              base_q   <= dec.use_sp ? sp_base : gpr_base;
              wide_q   <= dec.wide;
              sext_q   <= dec.sext;
              scaled_q <= dec.scaled;
              pred_q   <= pred_lane;
              idx_q    <= index_vec;
              result   <= '0;
              lane     <= '0;
              state    <= ST_SCAN;
            end
          end
        end
        ST_SCAN: begin
          if (pred_q[lane]) begin
            req_valid <= 1'b1;
            req_addr  <= lane_addr;
            state     <= ST_REQ;
          end else if (lane == LAST_LANE) begin
            done  <= 1'b1;
            state <= ST_IDLE;
          end else begin
            lane <= lane + LANE_W'(1);
          end
        end
        ST_REQ: begin
          if (req_ready) begin
            req_valid <= 1'b0;
            state     <= ST_WAIT;
          end
        end
        ST_WAIT: begin
          if (rsp_valid) begin
            if (rsp_err) begin
              mem_fault <= 1'b1;
              state     <= ST_IDLE;
            end else begin
              result[lane*DATA_W +: DATA_W] <= rsp_data;
              if (lane == LAST_LANE) begin
                done  <= 1'b1;
                state <= ST_IDLE;
              end else begin
                lane  <= lane + LANE_W'(1);
                state <= ST_SCAN;
              end
            end
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/gather_ld_seq_chk.sv
module gather_ld_seq_chk #(
  parameter int ADDR_W = 64
) (
  input logic              clk,
  input logic              rst,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              rsp_ready,
  input logic              done,
  input logic              busy,
  input logic              undef_fault,
  input logic              align_fault,
  input logic              mem_fault
);
  assert_req_hold_R8: assert property (@(posedge clk) disable iff (rst)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_addr)));

  assert_single_outstanding_R8: assert property (@(posedge clk) disable iff (rst)
    req_valid |-> !rsp_ready);

  assert_done_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  assert_done_idle_R10: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  assert_undef_quiet_R2: assert property (@(posedge clk) disable iff (rst)
    undef_fault |-> (!busy && !req_valid && !done));

  assert_align_quiet_R7: assert property (@(posedge clk) disable iff (rst)
    align_fault |-> (!busy && !req_valid));

  assert_mem_fault_ends_R9: assert property (@(posedge clk) disable iff (rst)
    $rose(mem_fault) |-> (!busy && !done && !req_valid));

  assert_outcome_exclusive_R10: assert property (@(posedge clk) disable iff (rst)
    $onehot0({done, undef_fault, align_fault, mem_fault}));
endmodule

bind gather_ld_seq gather_ld_seq_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_addr    (req_addr),
  .rsp_ready   (rsp_ready),
  .done        (done),
  .busy        (busy),
  .undef_fault (undef_fault),
  .align_fault (align_fault),
  .mem_fault   (mem_fault)
);

// File: tb/gather_ld_seq_test.sv
module gather_ld_seq_test;
  localparam int LANES = 8;
  localparam int VW    = LANES * 64;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          start = 1'b0;
  logic [31:0]   instr = '0;
  logic [63:0]   gpr_base = '0, sp_base = '0;
  logic [VW-1:0] index_vec = '0;
  logic [LANES*8-1:0] pred = '0;
  logic          req_valid, req_ready, rsp_valid, rsp_ready, rsp_err;
  logic [63:0]   req_addr, rsp_data;
  logic [VW-1:0] result;
  logic          done, busy, undef_fault, align_fault, mem_fault;

  always #5 clk = ~clk;

  gather_ld_seq uut (
    .clk(clk), .rst(rst), .start(start), .instr(instr),
    .gpr_base(gpr_base), .sp_base(sp_base), .index_vec(index_vec), .pred(pred),
    .req_valid(req_valid), .req_addr(req_addr), .req_ready(req_ready),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_data(rsp_data), .rsp_err(rsp_err),
    .result(result), .done(done), .busy(busy),
    .undef_fault(undef_fault), .align_fault(align_fault), .mem_fault(mem_fault)
  );

  int          checks = 0, fails = 0;
  int          lat = 0;
  logic        err_en = 1'b0;
  logic [63:0] err_addr = '0;
  string       cur_tag = "R5";
  logic [63:0] exp_addr_q[$];

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic chkv(input bit ok, input string tag, input string what,
                      input logic [VW-1:0] act, input logic [VW-1:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic [63:0] mdata(input logic [63:0] a);
    return {a[31:0], a[63:32]} ^ 64'hC3C3_5A5A_0F0F_9696;
  endfunction

  function automatic logic [31:0] mk(input bit xs, input bit sc, input bit w,
                                     input logic [4:0] rn);
    return {9'b110001011, xs, sc, 5'd7, w, 2'b10, 3'd2, rn, 5'd9};
  endfunction

  // monitor: pops the expected address for each request and answers it
  initial begin
    req_ready = 1'b0; rsp_valid = 1'b0; rsp_data = '0; rsp_err = 1'b0;
    forever begin
      @(negedge clk);
      if (!rst && req_valid) begin
        logic [63:0] a;
        a = req_addr;
        if (exp_addr_q.size() == 0)
          chk(1'b0, "R6", "request with none expected", a, '0);
        else begin
          logic [63:0] e;
          e = exp_addr_q.pop_front();
          chk(a == e, cur_tag, "request address", a, e);
        end
        req_ready = 1'b1;
        @(negedge clk);
        req_ready = 1'b0;
        repeat (lat) @(negedge clk);
        rsp_valid = 1'b1;
        rsp_data  = mdata(a);
        rsp_err   = err_en && (a == err_addr);
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_err   = 1'b0;
      end
    end
  end

  // driver: builds the expectation, pushes addresses, runs and checks the outcome
  task automatic run(input logic [31:0] ins, input logic [63:0] gpr, input logic [63:0] sp,
                     input logic [VW-1:0] idx, input logic [LANES*8-1:0] pr, input string tag);
    logic        legal, use_sp, stop;
    logic [3:0]  exp_flags, act_flags;
    logic [VW-1:0] exp_res;
    logic [63:0] base;
    int          n;
    legal  = (ins[31:23] == 9'b110001011) && (ins[14:13] == 2'b10) && (!ins[15] || ins[22]);
    use_sp = (ins[9:5] == 5'd31);
    base   = use_sp ? sp : gpr;
    exp_res = '0;
    stop    = 1'b0;
    cur_tag = tag;
    if (!legal) exp_flags = 4'b0100;
    else if (use_sp && sp[3:0] != 4'h0) exp_flags = 4'b0010;
    else begin
      exp_flags = 4'b1000;
      for (int e = 0; e < LANES; e++) begin
        logic [63:0] iv, off, a;
        iv = idx[e*64 +: 64];
        if (ins[15]) off = iv;
        else if (ins[22]) off = {{32{iv[31]}}, iv[31:0]};
        else off = {32'h0, iv[31:0]};
        a = base + (ins[21] ? (off << 3) : off);
        if (pr[e*8] && !stop) begin
          exp_addr_q.push_back(a);
          exp_res[e*64 +: 64] = mdata(a);
          if (err_en && a == err_addr) begin
            stop = 1'b1;
            exp_flags = 4'b0001;
          end
        end
      end
    end
    @(negedge clk);
    instr = ins; gpr_base = gpr; sp_base = sp; index_vec = idx; pred = pr; start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    n = 0;
    while (!(done || undef_fault || align_fault || mem_fault) && n < 2000) begin
      @(negedge clk);
      n++;
    end
    if (n >= 2000) chk(1'b0, tag, "operation watchdog", n, 2000);
    act_flags = {done, undef_fault, align_fault, mem_fault};
    chk(act_flags == exp_flags, tag, "outcome {done,undef,align,mem}", act_flags, exp_flags);
    if (exp_flags == 4'b1000) chkv(result == exp_res, tag, "result vector", result, exp_res);
    @(negedge clk);
    chk(!done && !busy, "R10", "done pulse width / idle", {done, busy}, 0);
    repeat (3) @(negedge clk);
    chk(exp_addr_q.size() == 0, "R6", "expected requests left unissued", exp_addr_q.size(), 0);
    chk(!req_valid, "R9", "no request after outcome", req_valid, 0);
    if (exp_flags == 4'b1000) chkv(result == exp_res, "R10", "result held", result, exp_res);
    exp_addr_q.delete();
  endtask

  initial begin
    #1_000_000;
    fails++; checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    logic [VW-1:0] idx;
    logic [LANES*8-1:0] pr;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    chk({busy, done, req_valid, rsp_ready} == 4'b0, "R1", "control outputs", {busy, done, req_valid, rsp_ready}, 0);
    chk({undef_fault, align_fault, mem_fault} == 3'b0, "R1", "fault flags", {undef_fault, align_fault, mem_fault}, 0);
    chkv(result == '0, "R1", "result", result, '0);

    // R4: 64-bit scaled, all lanes
    for (int e = 0; e < LANES; e++) idx[e*64 +: 64] = 64'(e * 3 + 1);
    lat = 0;
    run(mk(1, 1, 1, 5'd3), 64'h1000, 64'h0, idx, {LANES{8'h01}}, "R4");

    // R6: sparse predicate with noise bits, 64-bit unscaled wrap (R5)
    for (int e = 0; e < LANES; e++) idx[e*64 +: 64] = 64'hFFFF_FFFF_FFFF_FFF0 + 64'(e);
    for (int e = 0; e < LANES; e++) pr[e*8 +: 8] = (e == 0 || e == 2 || e == 5 || e == 7) ? 8'hFF : 8'hFE;
    lat = 2;
    run(mk(1, 0, 1, 5'd4), 64'h100, 64'h0, idx, pr, "R6");

    // R3: 32-bit zero-extended, scaled (R4)
    for (int e = 0; e < LANES; e++) idx[e*64 +: 64] = {32'hABCD_0000 + 32'(e), 32'h8000_0000 + 32'(e * 16)};
    lat = 1;
    run(mk(0, 1, 0, 5'd2), 64'h2000_0000_0000, 64'h0, idx, {LANES{8'h01}}, "R3");

    // R3: 32-bit sign-extended, unscaled, wraps below zero (R5)
    run(mk(1, 0, 0, 5'd2), 64'h10, 64'h0, idx, {LANES{8'h01}}, "R3");

    // R4: 32-bit sign-extended negative offsets, scaled
    for (int e = 0; e < LANES; e++) idx[e*64 +: 64] = {32'h1234_5678, -32'(e)};
    lat = 3;
    run(mk(1, 1, 0, 5'd8), 64'h4000, 64'h0, idx, {LANES{8'h01}}, "R4");

    // R6: no active lanes
    run(mk(1, 1, 1, 5'd1), 64'h4000, 64'h0, idx, {LANES{8'hFE}}, "R6");

    // R2: illegal words
    run(mk(1, 1, 1, 5'd1) & 32'h7FFF_FFFF, 64'h4000, 64'h0, idx, {LANES{8'h01}}, "R2");
    run(mk(0, 1, 1, 5'd1), 64'h4000, 64'h0, idx, {LANES{8'h01}}, "R2");
    run(mk(1, 1, 1, 5'd1) | 32'h0000_2000, 64'h4000, 64'h0, idx, {LANES{8'h01}}, "R2");

    // R5: stack pointer base, aligned
    for (int e = 0; e < LANES; e++) idx[e*64 +: 64] = 64'(e * 5);
    lat = 0;
    run(mk(1, 1, 1, 5'd31), 64'hDEAD_0000, 64'h8000_0010, idx, {LANES{8'h01}}, "R5");

    // R7: stack pointer misaligned
    run(mk(1, 1, 1, 5'd31), 64'hDEAD_0000, 64'h8000_0018, idx, {LANES{8'h01}}, "R7");

    // R9: error on lane 3 ends the sequence
    err_en = 1'b1;
    err_addr = 64'h9000 + (64'(15) << 3);
    lat = 1;
    run(mk(1, 1, 1, 5'd6), 64'h9000, 64'h0, idx, {LANES{8'h01}}, "R9");
    err_en = 1'b0;

    // R10: recovery after a fault, flags cleared
    run(mk(1, 0, 1, 5'd6), 64'h9000, 64'h0, idx, {LANES{8'h01}}, "R10");

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule